// File: doc/BRIEF.md
# I2C Target Address Match and Acknowledge Sequencer

This block is the byte-level engine of an I2C target. A bus monitor supplies the sampled SCL and SDA levels and single-cycle pulses for START and STOP, which also covers a repeated START. After each START the engine shifts in the header byte and compares it with a programmable own address. The address can be 7 bits wide or 10 bits wide, and the general-call address can be accepted on request. On a match the engine acknowledges the header, records the direction bit and then moves data bytes in either direction.

When the master writes, each received byte is presented on a byte-wide output together with a one-cycle valid strobe. The ninth clock of each byte then carries the acknowledge value that has been programmed. When the master reads, the engine takes a byte from the transmit input, drives it out MSB first and watches the master's acknowledge to decide whether to continue. SDA is only ever pulled low, and only while SCL is low. The surrounding logic turns the pull-low request into an open-drain pad.

Top module: `i2c_tgt_engine`

## Requirements
- R1: After reset, sda_drive_o, addressed_o, gen_call_o, rd_dir_o, rx_valid_o and tx_req_o are all 0.
- R2: In 7-bit mode, a header whose upper seven bits equal own_addr_i[6:0] is acknowledged: SDA is held low during the ninth SCL pulse. After the falling SCL edge that ends that pulse, addressed_o is 1 and rd_dir_o equals header bit 0 (1 = master reads, 0 = master writes).
- R3: A header that matches nothing is not acknowledged. The engine then releases SDA and delivers no data until the next START.
- R4: With gen_call_en_i set, the header 0x00 is acknowledged and raises both gen_call_o and addressed_o. With gen_call_en_i clear, 0x00 is not acknowledged.
- R5: A written byte appears on rx_data_o, shifted MSB first on rising SCL edges, with exactly one rx_valid_o pulse. SDA during its ninth clock is pulled low only when ack_val_i is 0 (1 = NACK).
- R6: In a read, tx_data_i is sampled at the SCL falling edge that ends the preceding acknowledge, and tx_req_o pulses in the next cycle. The byte is driven MSB first, and SDA changes only while SCL is low.
- R7: A master ACK (SDA 0 on the ninth clock) continues with the next byte. A master NACK makes the engine release SDA, so later reads see 0xFF.
- R8: STOP clears addressed_o and gen_call_o. A START, including a repeated START, clears addressed_o.
- R9: In 10-bit mode, a first byte of 11110, own_addr_i[9:8] and 0 is acknowledged, followed by a second byte equal to own_addr_i[7:0]. A 7-bit-style header is not acknowledged.
- R10: In 10-bit mode, after a fully matched 10-bit write header, a repeated START followed by 11110, own_addr_i[9:8] and 1 is acknowledged and starts a read with rd_dir_o = 1. Without such a prior match since the last STOP, that byte is not acknowledged.
- R11: With enable_i low, the engine never pulls SDA low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Engine enable |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level |
| start_i | input | 1 | START or repeated START pulse |
| stop_i | input | 1 | STOP pulse |
| own_addr_i | input | 10 | Own address (7-bit mode uses bits 6:0) |
| ten_bit_i | input | 1 | Select 10-bit addressing |
| gen_call_en_i | input | 1 | Accept the general-call address |
| ack_val_i | input | 1 | Acknowledge value for received bytes, 1 = NACK |
| tx_data_i | input | 8 | Next byte to transmit |
| sda_drive_o | output | 1 | 1 = pull SDA low |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| tx_req_o | output | 1 | Pulse: tx_data_i was taken, present the next byte |
| addressed_o | output | 1 | Addressed as target |
| gen_call_o | output | 1 | Addressed by general call |
| rd_dir_o | output | 1 | Captured direction bit |

## Verification
An SCL edge is registered on the first clock edge after the level changes. Pull-low requests and rx_valid_o therefore change one cycle after SCL falls. addressed_o follows the fall that ends the header's ninth clock, and tx_req_o follows one cycle after tx_data_i is taken. The bench holds each SCL phase for eight cycles and samples the bus four cycles into the high phase. It checks the flags only after driving SCL low and waiting four cycles, so each result is read several cycles after it is due and well before the next edge.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_ACK_HDR,
        ST_RCV,
        ST_XMIT,
        ST_ACK_DATA,
        ST_WAIT_ACK
    } eng_state_e;

    typedef struct packed {
        eng_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic               drive;
        logic               aas;
        logic               abgc;
        logic               srw;
        logic               ten_ok;
        logic               second;
        logic               pend2;
        logic               hdr_rd;
        logic               hdr_gc;
        logic               mack;
        logic [BYTE_W-1:0]  rx;
        logic               rxv;
        logic               txr;
    } eng_regs_t;
endpackage

// File: rtl/i2ct_edge.sv
module i2ct_edge #(
    parameter bit IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE_LEVEL;
        else        prev_q <= line_i;
    end

    assign rise_o = line_i & ~prev_q;
    assign fall_o = ~line_i & prev_q;
endmodule

// File: rtl/i2ct_match.sv
module i2ct_match
    import i2ct_pkg::*;
(
    input  logic [BYTE_W-1:0] hdr_i,
    input  logic              second_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              ten_bit_i,
    input  logic              gc_en_i,
    input  logic              ten_ok_i,
    output logic              match_o,
    output logic              gc_o,
    output logic              need2_o,
    output logic              read_o
);
    localparam logic [4:0] TEN_TAG = 5'b11110;

    logic is_gc, ten_hi;

    assign is_gc  = gc_en_i && (hdr_i == '0);
    assign ten_hi = (hdr_i[7:3] == TEN_TAG) && (hdr_i[2:1] == own_addr_i[9:8]);

    always_comb begin
        match_o = 1'b0;
        gc_o    = 1'b0;
        need2_o = 1'b0;
        read_o  = 1'b0;
        if (second_i) begin
            match_o = (hdr_i == own_addr_i[7:0]);
        end else if (is_gc) begin
            match_o = 1'b1;
            gc_o    = 1'b1;
        end else if (ten_bit_i) begin
            if (ten_hi && !hdr_i[0]) begin
                match_o = 1'b1;
                need2_o = 1'b1;
            end else if (ten_hi && hdr_i[0] && ten_ok_i) begin
                match_o = 1'b1;
                read_o  = 1'b1;
            end
        end else if (hdr_i[7:1] == own_addr_i[6:0]) begin
            match_o = 1'b1;
            read_o  = hdr_i[0];
        end
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2ct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              ten_bit_i,
    input  logic              gen_call_en_i,
    input  logic              ack_val_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    output logic              sda_drive_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              tx_req_o,
    output logic              addressed_o,
    output logic              gen_call_o,
    output logic              rd_dir_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    eng_regs_t q, d;
    logic scl_rise, scl_fall;
    logic m_hit, m_gc, m_need2, m_read;

    i2ct_edge #(.IDLE_LEVEL(1'b1)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (scl_i),
        .rise_o (scl_rise),
        .fall_o (scl_fall)
    );

    i2ct_match u_match (
        .hdr_i      (q.sh),
        .second_i   (q.second),
        .own_addr_i (own_addr_i),
        .ten_bit_i  (ten_bit_i),
        .gc_en_i    (gen_call_en_i),
        .ten_ok_i   (q.ten_ok),
        .match_o    (m_hit),
        .gc_o       (m_gc),
        .need2_o    (m_need2),
        .read_o     (m_read)
    );

    always_comb begin
        d     = q;
        d.rxv = 1'b0;
        d.txr = 1'b0;
        if (!enable_i) begin
            d.st     = ST_IDLE;
            d.drive  = 1'b0;
            d.aas    = 1'b0;
            d.abgc   = 1'b0;
            d.ten_ok = 1'b0;
        end else if (start_i) begin
            d.st     = ST_HEADER;
            d.cnt    = '0;
            d.drive  = 1'b0;
            d.aas    = 1'b0;
            d.abgc   = 1'b0;
            d.second = 1'b0;
        end else if (stop_i) begin
            d.st     = ST_IDLE;
            d.drive  = 1'b0;
            d.aas    = 1'b0;
            d.abgc   = 1'b0;
            d.ten_ok = 1'b0;
        end else begin
            unique case (q.st)
                ST_HEADER: begin
                    if (scl_rise && q.cnt != FULL) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == FULL) begin
                        if (m_hit) begin
                            d.st     = ST_ACK_HDR;
                            d.drive  = 1'b1;
                            d.pend2  = m_need2;
                            d.hdr_rd = m_read;
                            d.hdr_gc = m_gc;
                        end else begin
                            d.st    = ST_IDLE;
                            d.drive = 1'b0;
                        end
                    end
                end
                ST_ACK_HDR: begin
                    if (scl_fall) begin
                        d.drive = 1'b0;
                        d.cnt   = '0;
                        if (q.pend2) begin
                            d.st     = ST_HEADER;
                            d.second = 1'b1;
                        end else begin
                            d.aas  = 1'b1;
                            d.abgc = q.hdr_gc;
                            d.srw  = q.hdr_rd;
                            if (q.second) d.ten_ok = 1'b1;
                            if (q.hdr_rd) begin
                                d.st    = ST_XMIT;
                                d.sh    = tx_data_i;
                                d.drive = ~tx_data_i[BYTE_W-1];
                                d.txr   = 1'b1;
                            end else begin
                                d.st = ST_RCV;
                            end
                        end
                    end
                end
                ST_RCV: begin
                    if (scl_rise && q.cnt != FULL) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == FULL) begin
                        d.rx    = q.sh;
                        d.rxv   = 1'b1;
                        d.st    = ST_ACK_DATA;
                        d.drive = ~ack_val_i;
                    end
                end
                ST_ACK_DATA: begin
                    if (scl_fall) begin
                        d.drive = 1'b0;
                        d.cnt   = '0;
                        d.st    = ST_RCV;
                    end
                end
                ST_XMIT: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST) begin
                            d.drive = 1'b0;
                            d.st    = ST_WAIT_ACK;
                        end else begin
                            d.sh    = {q.sh[BYTE_W-2:0], 1'b0};
                            d.drive = ~q.sh[BYTE_W-2];
                            d.cnt   = q.cnt + 1'b1;
                        end
                    end
                end
                ST_WAIT_ACK: begin
                    if (scl_rise) begin
                        d.mack = sda_i;
                    end else if (scl_fall) begin
                        if (!q.mack) begin
                            d.st    = ST_XMIT;
                            d.cnt   = '0;
                            d.sh    = tx_data_i;
                            d.drive = ~tx_data_i[BYTE_W-1];
                            d.txr   = 1'b1;
                        end else begin
                            d.st    = ST_IDLE;
                            d.drive = 1'b0;
                        end
                    end
                end
                default: begin
                    d.drive = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_drive_o = q.drive;
    assign rx_data_o   = q.rx;
    assign rx_valid_o  = q.rxv;
    assign tx_req_o    = q.txr;
    assign addressed_o = q.aas;
    assign gen_call_o  = q.abgc;
    assign rd_dir_o    = q.srw;
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic scl_i,
    input logic start_i,
    input logic stop_i,
    input logic sda_drive_o,
    input logic rx_valid_o,
    input logic tx_req_o,
    input logic addressed_o,
    input logic gen_call_o
);
    AST_OFF_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !sda_drive_o); // R11

    AST_STOP_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && stop_i && !start_i) |=> (!addressed_o && !gen_call_o)); // R8

    AST_START_CLEARS_AAS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !addressed_o); // R8

    AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o); // R5

    AST_TXREQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_o |=> !tx_req_o); // R6

    AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && $past(enable_i) && !$past(start_i) && !$past(stop_i))
        |-> $stable(sda_drive_o)); // R6

    AST_GC_IMPLIES_AAS: assert property (@(posedge clk) disable iff (!rst_n)
        gen_call_o |-> addressed_o); // R4
endmodule

bind i2c_tgt_engine i2ct_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable_i),
    .scl_i       (scl_i),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .sda_drive_o (sda_drive_o),
    .rx_valid_o  (rx_valid_o),
    .tx_req_o    (tx_req_o),
    .addressed_o (addressed_o),
    .gen_call_o  (gen_call_o)
);

// File: tb/tb_i2c_tgt_engine.sv
module tb_i2c_tgt_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [9:0] own_addr = 10'h02A;
    logic       ten_bit = 1'b0;
    logic       gc_en = 1'b0;
    logic       ack_val = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       sda_drive_o, rx_valid_o, tx_req_o, addressed_o, gen_call_o, rd_dir_o;
    logic [7:0] rx_data_o;
    logic       sda_bus;

    int checks = 0;
    int fails = 0;
    int rx_cnt = 0;
    int txr_cnt = 0;
    logic [7:0] rx_last = 8'h00;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_drive_o;

    i2c_tgt_engine dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (enable_i),
        .scl_i         (scl),
        .sda_i         (sda_bus),
        .start_i       (start_i),
        .stop_i        (stop_i),
        .own_addr_i    (own_addr),
        .ten_bit_i     (ten_bit),
        .gen_call_en_i (gc_en),
        .ack_val_i     (ack_val),
        .tx_data_i     (tx_data),
        .sda_drive_o   (sda_drive_o),
        .rx_data_o     (rx_data_o),
        .rx_valid_o    (rx_valid_o),
        .tx_req_o      (tx_req_o),
        .addressed_o   (addressed_o),
        .gen_call_o    (gen_call_o),
        .rd_dir_o      (rd_dir_o)
    );

    always @(negedge clk) begin
        if (rx_valid_o) begin
            rx_cnt  = rx_cnt + 1;
            rx_last = rx_data_o;
        end
        if (tx_req_o) txr_cnt = txr_cnt + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic mbit, output logic seen);
        @(negedge clk) scl = 1'b0;
        wait_n(2);
        sda_m = mbit;
        wait_n(6);
        scl = 1'b1;
        wait_n(4);
        seen = sda_bus;
        wait_n(4);
    endtask

    task automatic scl_low();
        @(negedge clk) scl = 1'b0;
        wait_n(4);
    endtask

    task automatic do_start();
        @(negedge clk) scl = 1'b0;
        wait_n(4);
        sda_m = 1'b1;
        wait_n(4);
        scl = 1'b1;
        wait_n(4);
        sda_m = 1'b0;
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        wait_n(4);
    endtask

    task automatic do_stop();
        @(negedge clk) scl = 1'b0;
        wait_n(4);
        sda_m = 1'b0;
        wait_n(4);
        scl = 1'b1;
        wait_n(4);
        sda_m = 1'b1;
        stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
        wait_n(4);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, ack);
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(mack, s);
    endtask

    task automatic t_reset();
        check("R1 drive", sda_drive_o, 0);
        check("R1 aas", addressed_o, 0);
        check("R1 gc", gen_call_o, 0);
        check("R1 dir", rd_dir_o, 0);
        check("R1 rxv", rx_valid_o, 0);
        check("R1 txreq", tx_req_o, 0);
    endtask

    task automatic t_write7();
        logic a;
        int n0;
        ack_val = 1'b0;
        do_start();
        wr_byte({7'h2A, 1'b0}, a);
        check("R2 header ack", a, 0);
        scl_low();
        check("R2 aas", addressed_o, 1);
        check("R2 dir", rd_dir_o, 0);
        n0 = rx_cnt;
        wr_byte(8'hA5, a);
        check("R5 ack0", a, 0);
        check("R5 data", rx_last, 8'hA5);
        check("R5 one strobe", rx_cnt - n0, 1);
        ack_val = 1'b1;
        wr_byte(8'h3C, a);
        check("R5 nack", a, 1);
        check("R5 data2", rx_last, 8'h3C);
        ack_val = 1'b0;
        do_stop();
        check("R8 stop clears aas", addressed_o, 0);
    endtask

    task automatic t_mismatch();
        logic a;
        int n0;
        do_start();
        wr_byte({7'h2B, 1'b0}, a);
        check("R3 header nack", a, 1);
        n0 = rx_cnt;
        wr_byte(8'h55, a);
        check("R3 data nack", a, 1);
        check("R3 no data", rx_cnt - n0, 0);
        do_stop();
    endtask

    task automatic t_gc();
        logic a;
        gc_en = 1'b1;
        do_start();
        wr_byte(8'h00, a);
        check("R4 gc ack", a, 0);
        scl_low();
        check("R4 gc flag", gen_call_o, 1);
        check("R4 aas", addressed_o, 1);
        do_stop();
        check("R8 stop clears gc", gen_call_o, 0);
        gc_en = 1'b0;
        do_start();
        wr_byte(8'h00, a);
        check("R4 gc off nack", a, 1);
        scl_low();
        check("R4 gc flag off", gen_call_o, 0);
        do_stop();
    endtask

    task automatic t_read7();
        logic a;
        logic [7:0] b;
        int t0;
        t0 = txr_cnt;
        tx_data = 8'hC3;
        do_start();
        wr_byte({7'h2A, 1'b1}, a);
        check("R2 read header ack", a, 0);
        rd_byte(1'b0, b);
        check("R6 first byte", b, 8'hC3);
        check("R2 dir read", rd_dir_o, 1);
        tx_data = 8'h5E;
        rd_byte(1'b1, b);
        check("R7 byte after ack", b, 8'h5E);
        rd_byte(1'b1, b);
        check("R7 released after nack", b, 8'hFF);
        check("R6 request count", txr_cnt - t0, 2);
        do_stop();
    endtask

    task automatic t_rstart();
        logic a;
        do_start();
        wr_byte({7'h2A, 1'b0}, a);
        scl_low();
        check("R8 aas before sr", addressed_o, 1);
        do_start();
        check("R8 sr clears aas", addressed_o, 0);
        wr_byte({7'h11, 1'b0}, a);
        check("R3 other addr nack", a, 1);
        do_stop();
    endtask

    task automatic t_ten();
        logic a;
        logic [7:0] b;
        ten_bit = 1'b1;
        own_addr = 10'h2D6;
        do_start();
        wr_byte(8'hF4, a);
        check("R9 first byte ack", a, 0);
        wr_byte(8'hD6, a);
        check("R9 second byte ack", a, 0);
        scl_low();
        check("R9 aas", addressed_o, 1);
        wr_byte(8'h81, a);
        check("R9 data", rx_last, 8'h81);
        tx_data = 8'h6B;
        do_start();
        wr_byte(8'hF5, a);
        check("R10 read header ack", a, 0);
        rd_byte(1'b1, b);
        check("R10 dir", rd_dir_o, 1);
        check("R10 read byte", b, 8'h6B);
        do_stop();
        do_start();
        wr_byte(8'hF5, a);
        check("R10 no prior match nack", a, 1);
        do_stop();
        do_start();
        wr_byte(8'hAC, a);
        check("R9 seven-bit style nack", a, 1);
        do_stop();
        ten_bit = 1'b0;
        own_addr = 10'h02A;
    endtask

    task automatic t_disable();
        logic a;
        enable_i = 1'b0;
        do_start();
        wr_byte({7'h2A, 1'b0}, a);
        check("R11 no ack when off", a, 1);
        do_stop();
        enable_i = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        wait_n(5);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        wait_n(3);
        t_reset();
        t_write7();
        t_mismatch();
        t_gc();
        t_read7();
        t_rstart();
        t_ten();
        t_disable();
        wait_n(10);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule